// File: doc/BRIEF.md
# Privileged Stack Switch Validator

This block screens the inner-level stack that an interrupt or trap switches to when it enters a more privileged level. The new stack comes from the task state segment, and the entry may start in protected mode or in virtual-8086 mode. The requester presents the new stack-segment selector together with the descriptor attributes it has already fetched. It also presents the target code-segment privilege, the gate width, the new stack pointer and the stack limit, the instruction pointer and the code-segment limit. For an entry from virtual-8086 mode it adds the I/O privilege level, the gate privilege and the target privilege.

All checks are evaluated combinationally, in one cycle, in a fixed priority order. One cycle after a request the block reports either a pass or the first failing check. That report gives the fault class and the error code that the fault would push. The block does not load segment registers, move the stack pointer or write the frame; a sequencer around it uses the verdict to decide whether to continue or to raise the reported fault.

Fault class encoding on `rsp_kind`: 0 = none, 1 = invalid task state, 2 = stack fault, 3 = general protection. A selector-based error code is the selector with its two requestor-privilege bits replaced by `{0, ext_event}`, that is `{ss_sel[15:2], 1'b0, ext_event}`.

Top module: `stack_switch_validator`

## Requirements
- R1: A request in cycle N produces `rsp_valid`=1 in cycle N+1. In a cycle after one without a request, `rsp_valid` is 0 and `rsp_pass`, `rsp_kind` and `rsp_code` keep their values.
- R2: A null selector (`ss_sel[15:2]`==0, whatever its low two bits) gives kind 1 with code `{15'b0, ext_event}`.
- R3: Each of the following gives kind 1 with the selector-based code: `ss_idx_in_limit`=0, `ss_sel[1:0]` != `code_dpl`, `ss_desc_dpl` != `code_dpl`, or `ss_desc_wr_data`=0.
- R4: `ss_desc_present`=0 gives kind 2 with the selector-based code.
- R5: The frame size is 20 bytes when `gate_is_32`=1 and 10 bytes otherwise. The stack has room only if `new_sp` >= frame size and `new_sp`-1 <= `ss_limit`; otherwise the result is kind 2 with code 0.
- R6: `ip` > `cs_limit` gives kind 3 with code 0. `ip` == `cs_limit` is accepted.
- R7: With `v86_entry`=1, `iopl` != 3 gives kind 3 with code 0.
- R8: With `v86_entry`=1, `gate_dpl` != 3 or `target_cpl` != 0 gives kind 3 with code 0. With `v86_entry`=0, `iopl`, `gate_dpl` and `target_cpl` have no effect.
- R9: When several checks fail, the one reported is the first in this order: null, index limit, selector RPL, descriptor DPL, writable data, present, room, instruction pointer, IOPL, gate DPL, target CPL.
- R10: When no check fails, `rsp_pass`=1, `rsp_kind`=0 and `rsp_code`=0. On a failure, `rsp_pass`=0 and `rsp_kind` is non-zero.
- R11: During reset, `rsp_valid`, `rsp_pass`, `rsp_kind` and `rsp_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Evaluate the presented operands this cycle |
| v86_entry | input | 1 | The interrupt arrives from virtual-8086 mode |
| ext_event | input | 1 | Event is external; goes into bit 0 of the error codes |
| ss_sel | input | 16 | New stack-segment selector from the task state segment |
| ss_idx_in_limit | input | 1 | Selector index lies within its descriptor table |
| ss_desc_dpl | input | 2 | Privilege level of the stack descriptor |
| ss_desc_wr_data | input | 1 | Descriptor is a writable data segment |
| ss_desc_present | input | 1 | Descriptor present bit |
| code_dpl | input | 2 | Privilege level of the target code segment |
| gate_is_32 | input | 1 | Gate is 32-bit (20-byte frame) rather than 16-bit (10-byte) |
| new_sp | input | 32 | New stack pointer from the task state segment |
| ss_limit | input | 32 | Limit of the new stack segment |
| ip | input | 32 | Target instruction pointer |
| cs_limit | input | 32 | Limit of the target code segment |
| iopl | input | 2 | Current I/O privilege level (virtual-8086 entry) |
| gate_dpl | input | 2 | Privilege level of the gate (virtual-8086 entry) |
| target_cpl | input | 2 | Privilege level being entered (virtual-8086 entry) |
| rsp_valid | output | 1 | Verdict valid, one cycle after a request |
| rsp_pass | output | 1 | All checks passed |
| rsp_kind | output | 2 | Fault class of the first failing check |
| rsp_code | output | 16 | Error code of the first failing check |

## Verification
Every request ends in one registered verdict. A wrong priority chain, frame size, comparison edge or error-code mask therefore shows up at the ports one cycle after the request that exposes it. It appears as the wrong fault class or code, or as a pass where a fault was due. No state carries from one request to the next except the held outputs. A corrupted hold path shows in the first idle cycle, when the outputs change or `rsp_valid` fails to drop. The directed cases place the operands exactly on the boundaries: the frame size minus one, the limit plus one, and the null selector with non-zero RPL bits. They also combine failures, so that a misordered or shortened chain reports the wrong fault.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

  // fault classes
  localparam logic [1:0] FK_NONE    = 2'd0;
  localparam logic [1:0] FK_BAD_TSS = 2'd1;
  localparam logic [1:0] FK_STACK   = 2'd2;
  localparam logic [1:0] FK_GPROT   = 2'd3;

  // where an error code comes from
  localparam logic [1:0] EC_ZERO = 2'd0;
  localparam logic [1:0] EC_EXT  = 2'd1;
  localparam logic [1:0] EC_SEL  = 2'd2;

  // check positions, lowest index has highest priority
  localparam int CK_NULL    = 0;
  localparam int CK_LIMIT   = 1;
  localparam int CK_RPL     = 2;
  localparam int CK_DPL     = 3;
  localparam int CK_TYPE    = 4;
  localparam int CK_PRESENT = 5;
  localparam int CK_ROOM    = 6;
  localparam int CK_IP      = 7;
  localparam int CK_IOPL    = 8;
  localparam int CK_GDPL    = 9;
  localparam int CK_CPL     = 10;
  localparam int NCHK       = 11;

  localparam int DESC_CHECKS  = 6;
  localparam int BOUND_CHECKS = 2;
  localparam int V86_CHECKS   = 3;

  function automatic logic [1:0] chk_kind(input int idx);
    if (idx <= CK_TYPE)         return FK_BAD_TSS;
    else if (idx <= CK_ROOM)    return FK_STACK;
    else                        return FK_GPROT;
  endfunction

  function automatic logic [1:0] chk_code_src(input int idx);
    if (idx == CK_NULL)                          return EC_EXT;
    else if (idx <= CK_PRESENT)                  return EC_SEL;
    else                                         return EC_ZERO;
  endfunction

endpackage

// File: rtl/ssv_desc_screen.sv
module ssv_desc_screen #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0]                 sel,
  input  logic                             idx_in_limit,
  input  logic [1:0]                       desc_dpl,
  input  logic                             wr_data,
  input  logic                             present,
  input  logic [1:0]                       code_dpl,
  output logic [ssv_pkg::DESC_CHECKS-1:0]  fail
);
  import ssv_pkg::*;

  logic sel_is_null;
  assign sel_is_null = (sel[SEL_W-1:2] == '0);

  always_comb begin
    fail             = '0;
    fail[CK_NULL]    = sel_is_null;
    fail[CK_LIMIT]   = !idx_in_limit;
    fail[CK_RPL]     = (sel[1:0] != code_dpl);
    fail[CK_DPL]     = (desc_dpl != code_dpl);
    fail[CK_TYPE]    = !wr_data;
    fail[CK_PRESENT] = !present;
  end

endmodule

// File: rtl/ssv_bounds_screen.sv
module ssv_bounds_screen #(
  parameter int ADDR_W       = 32,
  parameter int FRAME_WIDE   = 20,
  parameter int FRAME_NARROW = 10
) (
  input  logic                              gate_is_32,
  input  logic [ADDR_W-1:0]                 new_sp,
  input  logic [ADDR_W-1:0]                 ss_limit,
  input  logic [ADDR_W-1:0]                 ip,
  input  logic [ADDR_W-1:0]                 cs_limit,
  output logic [ssv_pkg::BOUND_CHECKS-1:0]  fail
);
  localparam logic [ADDR_W-1:0] FW = ADDR_W'(FRAME_WIDE);
  localparam logic [ADDR_W-1:0] FN = ADDR_W'(FRAME_NARROW);

  // expand-up stack: frame sits just below sp, top byte must be in limit
  function automatic logic room_ok(input logic [ADDR_W-1:0] sp,
                                   input logic [ADDR_W-1:0] lim,
                                   input logic [ADDR_W-1:0] frame);
    return (sp >= frame) && ((sp - ADDR_W'(1)) <= lim);
  endfunction

  function automatic logic in_limit(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] lim);
    return addr <= lim;
  endfunction

  logic [ADDR_W-1:0] frame_sel;
  assign frame_sel = gate_is_32 ? FW : FN;

  assign fail[0] = !room_ok(new_sp, ss_limit, frame_sel);
  assign fail[1] = !in_limit(ip, cs_limit);

endmodule

// File: rtl/ssv_v86_screen.sv
module ssv_v86_screen (
  input  logic                            v86_entry,
  input  logic [1:0]                      iopl,
  input  logic [1:0]                      gate_dpl,
  input  logic [1:0]                      target_cpl,
  output logic [ssv_pkg::V86_CHECKS-1:0]  fail
);
  logic [ssv_pkg::V86_CHECKS-1:0] raw;
  assign raw[0] = (iopl != 2'd3);
  assign raw[1] = (gate_dpl != 2'd3);
  assign raw[2] = (target_cpl != 2'd0);
  assign fail = v86_entry ? raw : '0;
endmodule

// File: rtl/ssv_first_fault.sv
module ssv_first_fault #(
  parameter int N = 11
) (
  input  logic [N-1:0] fail,
  output logic [N-1:0] first_oh,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign first_oh[i]  = fail[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | fail[i];
  end

  assign any = blocked[N];
endmodule

// File: rtl/stack_switch_validator.sv
module stack_switch_validator #(
  parameter int SEL_W        = 16,
  parameter int ADDR_W       = 32,
  parameter int FRAME_WIDE   = 20,
  parameter int FRAME_NARROW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              v86_entry,
  input  logic              ext_event,
  input  logic [SEL_W-1:0]  ss_sel,
  input  logic              ss_idx_in_limit,
  input  logic [1:0]        ss_desc_dpl,
  input  logic              ss_desc_wr_data,
  input  logic              ss_desc_present,
  input  logic [1:0]        code_dpl,
  input  logic              gate_is_32,
  input  logic [ADDR_W-1:0] new_sp,
  input  logic [ADDR_W-1:0] ss_limit,
  input  logic [ADDR_W-1:0] ip,
  input  logic [ADDR_W-1:0] cs_limit,
  input  logic [1:0]        iopl,
  input  logic [1:0]        gate_dpl,
  input  logic [1:0]        target_cpl,
  output logic              rsp_valid,
  output logic              rsp_pass,
  output logic [1:0]        rsp_kind,
  output logic [SEL_W-1:0]  rsp_code
);
  import ssv_pkg::*;

  // named internal events
  logic [DESC_CHECKS-1:0]  desc_fail;
  logic [BOUND_CHECKS-1:0] bound_fail;
  logic [V86_CHECKS-1:0]   v86_fail;
  logic [NCHK-1:0]         fail_vec;
  logic [NCHK-1:0]         first_oh;
  logic                    any_fault;
  logic [1:0]              kind_c;
  logic [1:0]              src_c;
  logic [SEL_W-1:0]        code_c;

  ssv_desc_screen #(.SEL_W(SEL_W)) u_desc (
    .sel          (ss_sel),
    .idx_in_limit (ss_idx_in_limit),
    .desc_dpl     (ss_desc_dpl),
    .wr_data      (ss_desc_wr_data),
    .present      (ss_desc_present),
    .code_dpl     (code_dpl),
    .fail         (desc_fail)
  );

  ssv_bounds_screen #(
    .ADDR_W       (ADDR_W),
    .FRAME_WIDE   (FRAME_WIDE),
    .FRAME_NARROW (FRAME_NARROW)
  ) u_bounds (
    .gate_is_32 (gate_is_32),
    .new_sp     (new_sp),
    .ss_limit   (ss_limit),
    .ip         (ip),
    .cs_limit   (cs_limit),
    .fail       (bound_fail)
  );

  ssv_v86_screen u_v86 (
    .v86_entry  (v86_entry),
    .iopl       (iopl),
    .gate_dpl   (gate_dpl),
    .target_cpl (target_cpl),
    .fail       (v86_fail)
  );

  assign fail_vec = {v86_fail, bound_fail, desc_fail};

  ssv_first_fault #(.N(NCHK)) u_first (
    .fail     (fail_vec),
    .first_oh (first_oh),
    .any      (any_fault)
  );

  always_comb begin
    kind_c = FK_NONE;
    src_c  = EC_ZERO;
    for (int i = 0; i < NCHK; i++) begin
      if (first_oh[i]) begin
        kind_c = kind_c | chk_kind(i);
        src_c  = src_c | chk_code_src(i);
      end
    end
  end

  always_comb begin
    case (src_c)
      EC_EXT:  code_c = {{(SEL_W-1){1'b0}}, ext_event};
      EC_SEL:  code_c = {ss_sel[SEL_W-1:2], 1'b0, ext_event};
      default: code_c = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pass  <= 1'b0;
      rsp_kind  <= FK_NONE;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pass <= !any_fault;
        rsp_kind <= kind_c;
        rsp_code <= code_c;
      end
    end
  end

endmodule

// File: rtl/ssv_checker.sv
module ssv_checker #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int N      = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              v86_entry,
  input logic              ext_event,
  input logic [SEL_W-1:0]  ss_sel,
  input logic [ADDR_W-1:0] ip,
  input logic [ADDR_W-1:0] cs_limit,
  input logic [1:0]        iopl,
  input logic [N-1:0]      first_oh,
  input logic              rsp_valid,
  input logic              rsp_pass,
  input logic [1:0]        rsp_kind,
  input logic [SEL_W-1:0]  rsp_code
);

  // R1
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_pass) && $stable(rsp_kind) && $stable(rsp_code)));

  // R2
  null_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ss_sel[SEL_W-1:2] == '0) |=>
      (rsp_kind == 2'd1 && rsp_code == {{(SEL_W-1){1'b0}}, $past(ext_event)}));

  // R6
  ip_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ip > cs_limit) |=> !rsp_pass);

  // R7
  v86_iopl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && v86_entry && iopl != 2'd3) |=> !rsp_pass);

  // R9
  no_hit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && first_oh == '0) |=> rsp_pass);

  // R10
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pass) |-> (rsp_kind == 2'd0 && rsp_code == '0));

  // R10
  fail_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pass) |-> rsp_kind != 2'd0);

endmodule

bind stack_switch_validator ssv_checker #(
  .SEL_W  (SEL_W),
  .ADDR_W (ADDR_W),
  .N      (ssv_pkg::NCHK)
) u_ssv_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .v86_entry (v86_entry),
  .ext_event (ext_event),
  .ss_sel    (ss_sel),
  .ip        (ip),
  .cs_limit  (cs_limit),
  .iopl      (iopl),
  .first_oh  (first_oh),
  .rsp_valid (rsp_valid),
  .rsp_pass  (rsp_pass),
  .rsp_kind  (rsp_kind),
  .rsp_code  (rsp_code)
);

// File: tb/sim_stack_switch_validator.sv
module sim_stack_switch_validator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        v86_entry, ext_event;
  logic [15:0] ss_sel;
  logic        ss_idx_in_limit, ss_desc_wr_data, ss_desc_present, gate_is_32;
  logic [1:0]  ss_desc_dpl, code_dpl, iopl, gate_dpl, target_cpl;
  logic [31:0] new_sp, ss_limit, ip, cs_limit;
  logic        rsp_valid, rsp_pass;
  logic [1:0]  rsp_kind;
  logic [15:0] rsp_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stack_switch_validator u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .v86_entry(v86_entry),
    .ext_event(ext_event), .ss_sel(ss_sel), .ss_idx_in_limit(ss_idx_in_limit),
    .ss_desc_dpl(ss_desc_dpl), .ss_desc_wr_data(ss_desc_wr_data),
    .ss_desc_present(ss_desc_present), .code_dpl(code_dpl), .gate_is_32(gate_is_32),
    .new_sp(new_sp), .ss_limit(ss_limit), .ip(ip), .cs_limit(cs_limit),
    .iopl(iopl), .gate_dpl(gate_dpl), .target_cpl(target_cpl),
    .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_kind(rsp_kind), .rsp_code(rsp_code)
  );

  task automatic compare(input string tag, input logic v, input logic p,
                         input logic [1:0] k, input logic [15:0] c);
    n_chk++;
    if ({rsp_valid, rsp_pass, rsp_kind, rsp_code} !== {v, p, k, c}) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b pass=%0b kind=%0d code=%h, want valid=%0b pass=%0b kind=%0d code=%h",
               tag, rsp_valid, rsp_pass, rsp_kind, rsp_code, v, p, k, c);
    end
  endtask

  // a healthy protected-mode entry to level 0
  task automatic good_ops();
    v86_entry = 1'b0; ext_event = 1'b1;
    ss_sel = 16'h0010; ss_idx_in_limit = 1'b1; ss_desc_dpl = 2'd0;
    ss_desc_wr_data = 1'b1; ss_desc_present = 1'b1; code_dpl = 2'd0;
    gate_is_32 = 1'b1; new_sp = 32'h0000_1000; ss_limit = 32'h0000_FFFF;
    ip = 32'h0000_0100; cs_limit = 32'h0000_FFFF;
    iopl = 2'd0; gate_dpl = 2'd0; target_cpl = 2'd3;
  endtask

  // operands already set at a negedge; pulse one request, sample next negedge
  task automatic issue(input string tag, input logic [1:0] k, input logic [15:0] c);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    compare(tag, 1'b1, (k == 2'd0), k, c);
  endtask

  task automatic t_reset();
    @(negedge clk);
    compare("R11 reset state", 1'b0, 1'b0, 2'd0, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_pass();
    good_ops(); issue("R10 clean pass level0", 2'd0, 16'h0);
    good_ops(); code_dpl = 2'd3; ss_sel = 16'h002B; ss_desc_dpl = 2'd3;
    issue("R10 clean pass level3", 2'd0, 16'h0);
  endtask

  task automatic t_null();
    good_ops(); ss_sel = 16'h0000; issue("R2 null ext=1", 2'd1, 16'h0001);
    good_ops(); ss_sel = 16'h0000; ext_event = 1'b0; issue("R2 null ext=0", 2'd1, 16'h0000);
    good_ops(); ss_sel = 16'h0003; code_dpl = 2'd3; ss_desc_dpl = 2'd3;
    issue("R2 null with rpl bits", 2'd1, 16'h0001);
  endtask

  task automatic t_desc();
    good_ops(); ss_idx_in_limit = 1'b0; issue("R3 index limit", 2'd1, 16'h0011);
    good_ops(); ss_sel = 16'h0011; issue("R3 rpl mismatch", 2'd1, 16'h0011);
    good_ops(); ss_desc_dpl = 2'd1; issue("R3 dpl mismatch", 2'd1, 16'h0011);
    good_ops(); ss_desc_wr_data = 1'b0; ext_event = 1'b0; issue("R3 not writable", 2'd1, 16'h0010);
    good_ops(); ss_sel = 16'h0014; ss_desc_present = 1'b0; issue("R4 not present ti", 2'd2, 16'h0015);
  endtask

  task automatic t_room();
    good_ops(); new_sp = 32'd20; issue("R5 wide exact", 2'd0, 16'h0);
    good_ops(); new_sp = 32'd19; issue("R5 wide short", 2'd2, 16'h0);
    good_ops(); gate_is_32 = 1'b0; new_sp = 32'd10; issue("R5 narrow exact", 2'd0, 16'h0);
    good_ops(); gate_is_32 = 1'b0; new_sp = 32'd9; issue("R5 narrow short", 2'd2, 16'h0);
    good_ops(); new_sp = 32'd0; issue("R5 sp zero", 2'd2, 16'h0);
    good_ops(); new_sp = 32'h0001_0000; issue("R5 top at limit", 2'd0, 16'h0);
    good_ops(); new_sp = 32'h0001_0001; issue("R5 top past limit", 2'd2, 16'h0);
  endtask

  task automatic t_ip();
    good_ops(); ip = cs_limit; issue("R6 ip at limit", 2'd0, 16'h0);
    good_ops(); ip = cs_limit + 32'd1; issue("R6 ip past limit", 2'd3, 16'h0);
  endtask

  task automatic t_v86();
    good_ops(); v86_entry = 1'b1; iopl = 2'd3; gate_dpl = 2'd3; target_cpl = 2'd0;
    issue("R8 v86 all ok", 2'd0, 16'h0);
    good_ops(); v86_entry = 1'b1; iopl = 2'd2; gate_dpl = 2'd3; target_cpl = 2'd0;
    issue("R7 v86 iopl low", 2'd3, 16'h0);
    good_ops(); v86_entry = 1'b1; iopl = 2'd3; gate_dpl = 2'd2; target_cpl = 2'd0;
    issue("R8 v86 gate dpl", 2'd3, 16'h0);
    good_ops(); v86_entry = 1'b1; iopl = 2'd3; gate_dpl = 2'd3; target_cpl = 2'd1;
    issue("R8 v86 target cpl", 2'd3, 16'h0);
    good_ops(); iopl = 2'd0; gate_dpl = 2'd1; target_cpl = 2'd2;
    issue("R8 screening ignored outside v86", 2'd0, 16'h0);
  endtask

  task automatic t_prio();
    good_ops(); ss_sel = 16'h0000; ss_desc_present = 1'b0; new_sp = 32'd0;
    issue("R9 null before present", 2'd1, 16'h0001);
    good_ops(); ss_desc_present = 1'b0; new_sp = 32'd1; issue("R9 present before room", 2'd2, 16'h0011);
    good_ops(); new_sp = 32'd3; ip = 32'hFFFF_FFFF; issue("R9 room before ip", 2'd2, 16'h0);
    good_ops(); ss_desc_wr_data = 1'b0; v86_entry = 1'b1; iopl = 2'd0;
    issue("R9 type before v86", 2'd1, 16'h0011);
    good_ops(); ss_idx_in_limit = 1'b0; ss_desc_present = 1'b0; issue("R9 limit before present", 2'd1, 16'h0011);
  endtask

  task automatic t_hold();
    good_ops(); ss_desc_dpl = 2'd2; issue("R1 setup fault", 2'd1, 16'h0011);
    good_ops();
    @(negedge clk);
    compare("R1 idle holds verdict", 1'b0, 1'b0, 2'd1, 16'h0011);
  endtask

  initial begin
    good_ops();
    t_reset();
    t_pass();
    t_null();
    t_desc();
    t_room();
    t_ip();
    t_v86();
    t_prio();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule